// File: doc/BRIEF.md
# Port Command and Status Register Unit

This unit holds the command register of one host-adapter storage port, together with the two DMA base-pointer registers and the device signature register. Software controls two enables in the command register: the command-engine start bit and the received-frame enable bit. The unit raises the matching running indications itself, and drops them again only after the engines report idle. Software cannot overwrite those running bits. The link power-state change field always reads as zero, because no power-state change is ever carried out.

The command-list base and received-frame base registers can be written at any time. While an engine is off, these registers may hold stale values. The values driven on the base outputs, which the DMA engines consume, are taken from the registers only at the moment the matching engine starts. A port reset clears the command state. It also reloads the signature register byte by byte from a fixed device signature set by a parameter.

Top module: `port_cmd_reg`

## Requirements
- R1: After global reset, the command word reads 0, both base outputs are 0, both running outputs are low, and the signature word reads the SIGNATURE parameter.
- R2: Register select 0 is the command word. A write there stores bit 0 (start) and bit 4 (frame-receive enable), and both read back as written on the next cycle.
- R3: Bits 31:28 of the command word (link power-state change field) and every bit other than 0, 4, 14 and 15 always read as zero, whatever is written.
- R4: Bit 14 (frame-receive running) and bit 15 (command running) are read-only. A write neither sets nor clears them.
- R5: Command running (bit 15 and output `cmdRunning`) rises at the first clock edge at which start is already stored as 1. Frame-receive running (bit 14 and `fisRunning`) rises the same way from frame-receive enable.
- R6: After start is cleared, command running stays high until a clock edge samples `engIdle` high while start is clear, and it falls at that edge.
- R7: After frame-receive enable is cleared, frame-receive running stays high until a clock edge samples `engIdle` high while the enable is clear, and it falls at that edge.
- R8: Register selects 1 and 2 are the command-list base and the received-frame base, readable and writable. `clbBase` and `fbBase` take the stored register value only at the edge where the matching running bit rises. Writes made while an engine is off or already running leave these outputs unchanged.
- R9: Register select 3 is the signature word: byte 0 is the count byte, bytes 1 to 3 are the low, mid and high address bytes. A port reset reloads all four bytes from SIGNATURE and clears start, frame-receive enable and both running bits. Writes to select 3 are ignored.
- R10: When a port reset and a command-word write fall in the same cycle, the port reset wins and the write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous global reset, active high |
| portReset | input | 1 | Port reset pulse, active high |
| engIdle | input | 1 | DMA engines report idle |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select (0 command, 1 list base, 2 frame base, 3 signature) |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the selected register (combinational) |
| clbBase | output | 32 | Command-list base in use by the engine |
| fbBase | output | 32 | Received-frame base in use by the engine |
| cmdRunning | output | 1 | Command engine running |
| fisRunning | output | 1 | Frame-receive engine running |

## Verification
Two functions can fall in the same cycle. The first pair is a port reset and a software write to the command word. The bench drives both while the engines are running, then checks that the command word reads zero, both running outputs are low, and the signature is intact. The second pair is a base-register write and the start edge that latches that register. This is provoked by rewriting a base while the engine runs and after it stops. In both cases the bench checks that the base output changes only when a running bit rises.

// File: rtl/portcmd_pkg.sv
package portcmd_pkg;
  localparam int REG_W   = 32;
  localparam int SEL_W   = 2;
  localparam int ST_BIT  = 0;
  localparam int FRE_BIT = 4;
  localparam int FR_BIT  = 14;
  localparam int CR_BIT  = 15;
  localparam int SIG_BYTES = REG_W / 8;

  typedef enum logic [SEL_W-1:0] {
    SEL_CMD = 2'd0,
    SEL_CLB = 2'd1,
    SEL_FB  = 2'd2,
    SEL_SIG = 2'd3
  } regSel_e;

  typedef struct packed {
    logic cmdWr;
    logic clbWr;
    logic fbWr;
    logic sigLoad;
    logic clbLatch;
    logic fbLatch;
  } strobe_t;
endpackage

// File: rtl/portcmd_ctrl.sv
module portcmd_ctrl
  import portcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             portReset,
  input  logic             engIdle,
  input  logic             regWrEn,
  input  logic [SEL_W-1:0] regAddr,
  input  logic             stEn,
  input  logic             freEn,
  output strobe_t          stb,
  output logic             cmdRunning,
  output logic             fisRunning
);
  regSel_e sel;
  logic    crNext;
  logic    frNext;

  assign sel = regSel_e'(regAddr);

  always_comb begin
    stb          = '0;
    stb.sigLoad  = portReset;
    stb.cmdWr    = regWrEn && !portReset && (sel == SEL_CMD);
    stb.clbWr    = regWrEn && (sel == SEL_CLB);
    stb.fbWr     = regWrEn && (sel == SEL_FB);
    stb.clbLatch = !portReset && stEn && !cmdRunning;
    stb.fbLatch  = !portReset && freEn && !fisRunning;
  end

  always_comb begin
    crNext = cmdRunning;
    if (portReset)                          crNext = 1'b0;
    else if (stEn && !cmdRunning)           crNext = 1'b1;
    else if (!stEn && cmdRunning && engIdle) crNext = 1'b0;
  end

  always_comb begin
    frNext = fisRunning;
    if (portReset)                           frNext = 1'b0;
    else if (freEn && !fisRunning)           frNext = 1'b1;
    else if (!freEn && fisRunning && engIdle) frNext = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdRunning <= 1'b0;
      fisRunning <= 1'b0;
    end else begin
      cmdRunning <= crNext;
      fisRunning <= frNext;
    end
  end

  // R5
  crRise_chk: assert property (@(posedge clk) disable iff (rst)
    stEn && !cmdRunning && !portReset |=> cmdRunning);

  // R6
  crHold_chk: assert property (@(posedge clk) disable iff (rst)
    cmdRunning && !portReset && (stEn || !engIdle) |=> cmdRunning);

  // R7
  frFall_chk: assert property (@(posedge clk) disable iff (rst)
    fisRunning && !freEn && engIdle && !portReset |=> !fisRunning);

  // R10
  rstWins_chk: assert property (@(posedge clk) disable iff (rst)
    portReset |=> !cmdRunning && !fisRunning);
endmodule

// File: rtl/portcmd_dp.sv
module portcmd_dp
  import portcmd_pkg::*;
#(
  parameter int               BASE_W    = 32,
  parameter logic [REG_W-1:0] SIGNATURE = 32'h0000_0101
)(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [SEL_W-1:0]  regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              cmdRunning,
  input  logic              fisRunning,
  output logic              stEn,
  output logic              freEn,
  output logic [REG_W-1:0]  regRdData,
  output logic [BASE_W-1:0] clbBase,
  output logic [BASE_W-1:0] fbBase
);
  logic [BASE_W-1:0] clbReg;
  logic [BASE_W-1:0] fbReg;
  logic [7:0]        sigByte [SIG_BYTES];
  logic [REG_W-1:0]  sigWord;
  logic [REG_W-1:0]  cmdWord;

  always_ff @(posedge clk) begin
    if (rst || stb.sigLoad) begin
      stEn  <= 1'b0;
      freEn <= 1'b0;
    end else if (stb.cmdWr) begin
      stEn  <= regWrData[ST_BIT];
      freEn <= regWrData[FRE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clbReg <= '0;
      fbReg  <= '0;
    end else begin
      if (stb.clbWr) clbReg <= regWrData[BASE_W-1:0];
      if (stb.fbWr)  fbReg  <= regWrData[BASE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clbBase <= '0;
      fbBase  <= '0;
    end else begin
      if (stb.clbLatch) clbBase <= clbReg;
      if (stb.fbLatch)  fbBase  <= fbReg;
    end
  end

  for (genvar g = 0; g < SIG_BYTES; g++) begin : g_sig
    always_ff @(posedge clk) begin
      if (rst || stb.sigLoad) sigByte[g] <= SIGNATURE[8*g +: 8];
    end
    assign sigWord[8*g +: 8] = sigByte[g];
  end

  always_comb begin
    cmdWord          = '0;
    cmdWord[ST_BIT]  = stEn;
    cmdWord[FRE_BIT] = freEn;
    cmdWord[FR_BIT]  = fisRunning;
    cmdWord[CR_BIT]  = cmdRunning;
  end

  always_comb begin
    unique case (regSel_e'(regAddr))
      SEL_CMD: regRdData = cmdWord;
      SEL_CLB: regRdData = REG_W'(clbReg);
      SEL_FB:  regRdData = REG_W'(fbReg);
      default: regRdData = sigWord;
    endcase
  end

  // R8
  clbHold_chk: assert property (@(posedge clk) disable iff (rst)
    !stb.clbLatch |=> $stable(clbBase));

  // R8
  fbHold_chk: assert property (@(posedge clk) disable iff (rst)
    !stb.fbLatch |=> $stable(fbBase));

  // R9
  portClr_chk: assert property (@(posedge clk) disable iff (rst)
    stb.sigLoad |=> !stEn && !freEn && (sigWord == SIGNATURE));
endmodule

// File: rtl/port_cmd_reg.sv
module port_cmd_reg
  import portcmd_pkg::*;
#(
  parameter int          BASE_W    = 32,
  parameter logic [31:0] SIGNATURE = 32'h0000_0101
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              portReset,
  input  logic              engIdle,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic [BASE_W-1:0] clbBase,
  output logic [BASE_W-1:0] fbBase,
  output logic              cmdRunning,
  output logic              fisRunning
);
  strobe_t stb;
  logic    stEn;
  logic    freEn;

  portcmd_ctrl u_ctrl (
    .clk(clk), .rst(rst), .portReset(portReset), .engIdle(engIdle),
    .regWrEn(regWrEn), .regAddr(regAddr), .stEn(stEn), .freEn(freEn),
    .stb(stb), .cmdRunning(cmdRunning), .fisRunning(fisRunning)
  );

  portcmd_dp #(.BASE_W(BASE_W), .SIGNATURE(SIGNATURE)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .regAddr(regAddr),
    .regWrData(regWrData), .cmdRunning(cmdRunning), .fisRunning(fisRunning),
    .stEn(stEn), .freEn(freEn), .regRdData(regRdData),
    .clbBase(clbBase), .fbBase(fbBase)
  );

  // R3
  iccZero_chk: assert property (@(posedge clk) disable iff (rst)
    (regAddr == 2'd0) |-> (regRdData[31:28] == 4'd0) && (regRdData[13:5] == 9'd0));
endmodule

// File: tb/port_cmd_reg_bench.sv
module port_cmd_reg_bench;
  localparam logic [31:0] SIG = 32'hEB14_0101;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        portReset = 1'b0;
  logic        engIdle = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] clbBase;
  logic [31:0] fbBase;
  logic        cmdRunning;
  logic        fisRunning;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  port_cmd_reg #(.BASE_W(32), .SIGNATURE(SIG)) u_port_cmd_reg (
    .clk(clk), .rst(rst), .portReset(portReset), .engIdle(engIdle),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .clbBase(clbBase), .fbBase(fbBase),
    .cmdRunning(cmdRunning), .fisRunning(fisRunning)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [1:0] a, input logic [31:0] exp);
    regAddr = a;
    #0.5;
    chk(req, regRdData, exp);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic idlePulse();
    engIdle = 1'b1;
    tick(1);
    engIdle = 1'b0;
  endtask

  task automatic t_reset();
    rdChk("R1 cmd", 2'd0, 32'h0);
    rdChk("R1 sig", 2'd3, SIG);
    chk("R1 clbBase", clbBase, 32'h0);
    chk("R1 fbBase", fbBase, 32'h0);
    chk("R1 running", {30'd0, cmdRunning, fisRunning}, 32'h0);
  endtask

  task automatic t_cmdBits();
    wr(2'd0, 32'hFFFF_FFEE);
    rdChk("R3 R4 ro bits on all-ones", 2'd0, 32'h0);
    tick(1);
    rdChk("R4 running stays clear", 2'd0, 32'h0);
    wr(2'd0, 32'hF000_C011);
    rdChk("R2 st fre stored", 2'd0, 32'h0000_0011);
    tick(1);
    rdChk("R5 running bits rise", 2'd0, 32'h0000_C011);
    wr(2'd0, 32'h0000_0000);
    rdChk("R4 R6 running held after clear", 2'd0, 32'h0000_C000);
    tick(3);
    rdChk("R6 R7 held without idle", 2'd0, 32'h0000_C000);
    idlePulse();
    rdChk("R6 R7 fall after idle", 2'd0, 32'h0);
  endtask

  task automatic t_partialStop();
    wr(2'd0, 32'h0000_0011);
    tick(1);
    wr(2'd0, 32'h0000_0001);
    idlePulse();
    chk("R7 fr falls, cr stays", {30'd0, cmdRunning, fisRunning}, 32'h2);
    wr(2'd0, 32'h0);
    idlePulse();
    chk("R6 cr falls", {30'd0, cmdRunning, fisRunning}, 32'h0);
  endtask

  task automatic t_latch();
    wr(2'd1, 32'h1000_0400);
    wr(2'd2, 32'h2000_0100);
    rdChk("R8 clb readback", 2'd1, 32'h1000_0400);
    rdChk("R8 fb readback", 2'd2, 32'h2000_0100);
    chk("R8 clbBase not latched while off", clbBase, 32'h0);
    chk("R8 fbBase not latched while off", fbBase, 32'h0);
    wr(2'd0, 32'h0000_0001);
    tick(1);
    chk("R8 clbBase latched on start", clbBase, 32'h1000_0400);
    chk("R8 fbBase untouched by start", fbBase, 32'h0);
    wr(2'd1, 32'h3000_0000);
    tick(1);
    chk("R8 clbBase held while running", clbBase, 32'h1000_0400);
    wr(2'd0, 32'h0000_0011);
    tick(1);
    chk("R8 fbBase latched on fre", fbBase, 32'h2000_0100);
    wr(2'd0, 32'h0);
    idlePulse();
    wr(2'd1, 32'h4444_0000);
    tick(1);
    chk("R8 stopped engine keeps old base", clbBase, 32'h1000_0400);
    wr(2'd0, 32'h0000_0001);
    tick(1);
    chk("R8 restart latches new base", clbBase, 32'h4444_0000);
    wr(2'd0, 32'h0);
    idlePulse();
  endtask

  task automatic t_portReset();
    wr(2'd0, 32'h0000_0011);
    tick(1);
    chk("R5 running before port reset", {30'd0, cmdRunning, fisRunning}, 32'h3);
    @(negedge clk);
    portReset = 1'b1; regWrEn = 1'b1; regAddr = 2'd0; regWrData = 32'h0000_0011;
    @(negedge clk);
    portReset = 1'b0; regWrEn = 1'b0;
    rdChk("R10 reset beats write", 2'd0, 32'h0);
    chk("R9 running cleared", {30'd0, cmdRunning, fisRunning}, 32'h0);
    rdChk("R9 signature after port reset", 2'd3, SIG);
    wr(2'd3, 32'h1234_5678);
    rdChk("R9 signature write ignored", 2'd3, SIG);
    tick(2);
    chk("R10 no late start", {30'd0, cmdRunning, fisRunning}, 32'h0);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_cmdBits();
    t_partialStop();
    t_latch();
    t_portReset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule